// File: doc/BRIEF.md
# Pseudo-Random Pixel Error Checker

This block sits behind a parallel video receiver on the test side of a digital display link. On every pixel clock it takes the 24-bit recovered pixel, the data-enable strobe and the vertical sync. It builds the expected pseudo-random pixel stream locally and compares each active pixel against it. The local stream comes from a 23-stage maximal-length shift register that starts from a fixed seed at a defined point in each frame. The block therefore aligns itself to the sender's stream with no outside alignment command. After each frame start it keeps a count of tested pixels and a count of failing pixels.

A pixel counts as one error when any of its 24 bits is wrong, however many bits are wrong. A synchronous clear input zeroes both counters, for example at the start of a timed measurement window. Both counters stop at their all-ones value rather than wrapping. A status flag shows that the reference has been seeded at least once since reset.

Top module: `pert_monitor`

## Requirements
- R1: During and after reset, both counters read zero and the lock flag is low.
- R2: The reference is a 23-bit state, numbered bit 1 to bit 23. Each clock the state moves one place towards bit 23, and bit 23 XOR bit 5 enters bit 1. The expected pixel is {bit 23 XOR bit 5, bits 23 down to 1}. Pixel bits [23:16] belong to channel 2, [15:8] to channel 1 and [7:0] to channel 0. The reference advances once on every pixel clock, whether or not the pixel is active.
- R3: The reference takes the seed 0x000001 (only bit 1 set) for the pixel on the first rising edge of DE that follows a clock with VSYNC high. Later DE rising edges with no new VSYNC continue the running sequence.
- R4: Until the first seed load, no pixel is tested or counted and the lock flag stays low. The flag rises on the clock after that load and stays high until reset.
- R5: Pixels presented while DE is low are neither compared nor counted, whatever their value.
- R6: Each compared pixel adds one to the tested-pixel counter.
- R7: A compared pixel with one or more wrong bits, in any channel, adds exactly one to the error counter.
- R8: Every frame re-seeds the reference. A stream that has slipped out of step fails every compared pixel until the next frame start, and from then on it is clean again.
- R9: A clear request zeroes both counters on the next clock. It takes priority over any increment in the same cycle.
- R10: Both counters hold at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_i | input | 1 | Data enable of the received pixel |
| vsync_i | input | 1 | Vertical sync of the received frame |
| pix_i | input | 24 | Received pixel, channel 2 in the top byte |
| clr_i | input | 1 | Synchronous clear of both counters |
| err_cnt_o | output | CNT_W | Failing pixel count |
| pix_cnt_o | output | CNT_W | Tested pixel count |
| sync_o | output | 1 | Reference seeded since reset |

## Verification
The clear request and a pixel increment can arrive on the same clock. The bench provokes this by asserting clear while it presents a corrupted active pixel in a locked stream. It then expects both counters to read zero, not one. The next corrupted pixel without clear must then read one on both counters. A second coincidence is the seed load and the comparison of the same first active pixel. A clean frame must therefore end with zero errors and a tested count equal to its active pixels.

// File: rtl/pert_pkg.sv
package pert_pkg;
  localparam int unsigned LFSR_W = 23;
  localparam int unsigned TAP_B  = 5;   // 1-based tap position
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_CH   = 3;
  localparam int unsigned PIX_W  = BYTE_W * N_CH;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [PIX_W-1:0]  pix_t;

  localparam lfsr_t SEED = lfsr_t'(1);

  function automatic logic lfsr_fb(lfsr_t s);
    return s[LFSR_W-1] ^ s[TAP_B-1];
  endfunction

  function automatic lfsr_t lfsr_step(lfsr_t s);
    return {s[LFSR_W-2:0], lfsr_fb(s)};
  endfunction

  function automatic pix_t lfsr_word(lfsr_t s);
    return {lfsr_fb(s), s};
  endfunction
endpackage

// File: rtl/pert_prbs_ref.sv
module pert_prbs_ref
  import pert_pkg::*;
#(
  parameter lfsr_t SEED_VAL = SEED
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output pix_t exp_o
);
  lfsr_t st_q;
  lfsr_t cur;

  // seed applies to the pixel of the load cycle itself
  assign cur   = load_i ? SEED_VAL : st_q;
  assign exp_o = lfsr_word(cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEED_VAL;
    else         st_q <= lfsr_step(cur);
  end
endmodule

// File: rtl/pert_frame_sync.sv
module pert_frame_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic de_i,
  input  logic vsync_i,
  output logic load_o,
  output logic lock_o
);
  logic de_q, armed_q, lock_q;

  assign load_o = de_i & ~de_q & armed_q;
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q    <= 1'b0;
      armed_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      de_q <= de_i;
      if (vsync_i)     armed_q <= 1'b1;
      else if (load_o) armed_q <= 1'b0;
      if (load_o)      lock_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/pert_pix_cmp.sv
module pert_pix_cmp #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_CH   = 3,
  localparam int unsigned PIX_W = BYTE_W * N_CH
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] exp_i,
  output logic             mis_o
);
  logic [N_CH-1:0] ch_mis;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch_mis[c] = |(pix_i[c*BYTE_W +: BYTE_W] ^ exp_i[c*BYTE_W +: BYTE_W]);
  end

  // any channel wrong -> one pixel error
  assign mis_o = |ch_mis;
endmodule

// File: rtl/pert_sat_cnt.sv
module pert_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAXV) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pert_monitor.sv
module pert_monitor
  import pert_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter lfsr_t       SEED_VAL = SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             de_i,
  input  logic             vsync_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic [CNT_W-1:0] pix_cnt_o,
  output logic             sync_o
);
  logic load, lock, mis, active;
  pix_t exp_pix;

  pert_frame_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .de_i    (de_i),
    .vsync_i (vsync_i),
    .load_o  (load),
    .lock_o  (lock)
  );

  pert_prbs_ref #(.SEED_VAL(SEED_VAL)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .exp_o  (exp_pix)
  );

  pert_pix_cmp #(.BYTE_W(BYTE_W), .N_CH(N_CH)) u_cmp (
    .pix_i (pix_i),
    .exp_i (exp_pix),
    .mis_o (mis)
  );

  assign active = de_i & (lock | load);

  pert_sat_cnt #(.W(CNT_W)) u_pix_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .inc_i  (active),
    .cnt_o  (pix_cnt_o)
  );

  pert_sat_cnt #(.W(CNT_W)) u_err_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .inc_i  (active & mis),
    .cnt_o  (err_cnt_o)
  );

  assign sync_o = lock;
endmodule

// File: rtl/pert_monitor_sva.sv
module pert_monitor_sva #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             de_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic [CNT_W-1:0] pix_cnt_o,
  input logic             sync_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  a_r4_idle_until_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o |-> (err_cnt_o == '0 && pix_cnt_o == '0));

  a_r4_sync_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> sync_o);

  a_r5_blank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!de_i && !clr_i) |=> ($stable(err_cnt_o) && $stable(pix_cnt_o)));

  a_r7_one_per_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (err_cnt_o == $past(err_cnt_o) || err_cnt_o == $past(err_cnt_o) + 1'b1));

  a_r7_err_le_pix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o <= pix_cnt_o);

  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_cnt_o == '0 && pix_cnt_o == '0));

  a_r10_pix_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_cnt_o == MAXV && !clr_i) |=> pix_cnt_o == MAXV);

  a_r10_err_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == MAXV && !clr_i) |=> err_cnt_o == MAXV);
endmodule

bind pert_monitor pert_monitor_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .de_i      (de_i),
  .clr_i     (clr_i),
  .err_cnt_o (err_cnt_o),
  .pix_cnt_o (pix_cnt_o),
  .sync_o    (sync_o)
);

// File: tb/pert_monitor_tb.sv
module pert_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int MAXC       = 255;

  typedef logic [22:0] st_t;
  typedef logic [23:0] px_t;
  localparam st_t TB_SEED = 23'h000001;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic de_i = 1'b0, vsync_i = 1'b0, clr_i = 1'b0;
  px_t  pix_i = '0;
  logic [CNT_W-1:0] err_cnt_o, pix_cnt_o;
  logic sync_o;

  int checks = 0, errors = 0;
  int unsigned m_err = 0, m_pix = 0;
  bit m_locked = 0, m_armed = 0, m_deq = 0;
  st_t r_st = TB_SEED, t_st = TB_SEED;

  always #(CLK_PERIOD/2) clk = ~clk;

  pert_monitor #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .de_i(de_i), .vsync_i(vsync_i), .pix_i(pix_i),
    .clr_i(clr_i), .err_cnt_o(err_cnt_o), .pix_cnt_o(pix_cnt_o), .sync_o(sync_o)
  );

  // reference model built from R2: bit23^bit5 enters bit1, word = {fb, bits 23..1}
  function automatic logic tb_fb(st_t s); return s[22] ^ s[4]; endfunction
  function automatic st_t tb_step(st_t s); return {s[21:0], tb_fb(s)}; endfunction
  function automatic px_t tb_word(st_t s); return {tb_fb(s), s}; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_model(input string req);
    chk(int'(err_cnt_o) == int'(m_err), {req, " err"}, int'(err_cnt_o), int'(m_err));
    chk(int'(pix_cnt_o) == int'(m_pix), {req, " pix"}, int'(pix_cnt_o), int'(m_pix));
    chk(sync_o == m_locked, {req, " sync"}, int'(sync_o), int'(m_locked));
  endtask

  // one pixel clock; mask corrupts the sent word
  task automatic cyc(input bit de, input bit vs, input bit clr, input px_t mask);
    bit load, en;
    st_t rc, tc;
    px_t data;
    @(negedge clk);
    load = de && !m_deq && m_armed;
    rc = load ? TB_SEED : r_st;
    tc = load ? TB_SEED : t_st;
    data = de ? (tb_word(tc) ^ mask) : (24'h5A5A5A ^ mask);
    de_i = de; vsync_i = vs; clr_i = clr; pix_i = data;
    en = de && (m_locked || load);
    if (clr) begin
      m_err = 0; m_pix = 0;
    end else if (en) begin
      if (m_pix < MAXC) m_pix++;
      if (data != tb_word(rc) && m_err < MAXC) m_err++;
    end
    r_st = tb_step(rc);
    t_st = tb_step(tc);
    if (vs) m_armed = 1; else if (load) m_armed = 0;
    if (load) m_locked = 1;
    m_deq = de;
    @(posedge clk); #1;
  endtask

  task automatic frame(input int lines, input int len, input int bad, input px_t mask);
    for (int i = 0; i < 2; i++) cyc(0, 1, 0, '0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 24'hFFFFFF);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < len; p++) cyc(1, 0, 0, (p == bad) ? mask : '0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 24'h00F00F);
    end
  endtask

  task automatic t_reset;
    chk(err_cnt_o == '0, "R1 err after reset", int'(err_cnt_o), 0);
    chk(pix_cnt_o == '0, "R1 pix after reset", int'(pix_cnt_o), 0);
    chk(sync_o == 1'b0, "R1 sync after reset", int'(sync_o), 0);
  endtask

  task automatic t_prelock;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 24'h000003);
    cyc(0, 0, 0, '0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 24'h010000);
    cyc(0, 0, 0, '0);
    chk(err_cnt_o == '0, "R4 no errors before seed", int'(err_cnt_o), 0);
    chk(pix_cnt_o == '0, "R4 no pixels before seed", int'(pix_cnt_o), 0);
    chk(sync_o == 1'b0, "R4 sync low before seed", int'(sync_o), 0);
  endtask

  task automatic t_clean;
    cyc(0, 0, 1, '0);
    frame(3, 20, -1, '0);
    chk(sync_o == 1'b1, "R4 sync after seed", int'(sync_o), 1);
    chk(pix_cnt_o == 8'd60, "R6 pixel count clean frame", int'(pix_cnt_o), 60);
    chk(err_cnt_o == '0, "R2 R3 clean multi-line frame", int'(err_cnt_o), 0);
    chk_model("R3");
  endtask

  task automatic t_single;
    cyc(0, 0, 1, '0);
    frame(3, 16, 5, 24'h000001);
    chk(err_cnt_o == 8'd3, "R7 single bit ch0", int'(err_cnt_o), 3);
    cyc(0, 0, 1, '0);
    frame(2, 16, 0, 24'h800000);
    chk(err_cnt_o == 8'd2, "R7 single bit ch2 first pixel", int'(err_cnt_o), 2);
    cyc(0, 0, 1, '0);
    frame(2, 16, 15, 24'h001000);
    chk(err_cnt_o == 8'd2, "R7 single bit ch1 last pixel", int'(err_cnt_o), 2);
    chk(pix_cnt_o == 8'd32, "R6 pixel count", int'(pix_cnt_o), 32);
  endtask

  task automatic t_multi;
    cyc(0, 0, 1, '0);
    frame(4, 12, 11, 24'hFFFFFF);
    chk(err_cnt_o == 8'd4, "R7 all bits wrong", int'(err_cnt_o), 4);
    chk(pix_cnt_o == 8'd48, "R6 pixel count multi", int'(pix_cnt_o), 48);
    cyc(0, 0, 1, '0);
    frame(3, 12, 2, 24'h010101);
    chk(err_cnt_o == 8'd3, "R7 one bit per channel", int'(err_cnt_o), 3);
  endtask

  task automatic t_blank;
    int unsigned e0, p0;
    e0 = err_cnt_o; p0 = pix_cnt_o;
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 24'h123456);
    chk(int'(err_cnt_o) == int'(e0), "R5 blank garbage err", int'(err_cnt_o), int'(e0));
    chk(int'(pix_cnt_o) == int'(p0), "R5 blank garbage pix", int'(pix_cnt_o), int'(p0));
  endtask

  task automatic t_resync;
    cyc(0, 0, 1, '0);
    frame(1, 10, -1, '0);
    t_st = tb_step(t_st);  // sender slips one position
    for (int p = 0; p < 10; p++) cyc(1, 0, 0, '0);
    cyc(0, 0, 0, '0);
    chk(err_cnt_o == 8'd10, "R8 slipped line all fail", int'(err_cnt_o), 10);
    cyc(0, 0, 1, '0);
    frame(2, 10, -1, '0);
    chk(err_cnt_o == '0, "R8 recovered after frame start", int'(err_cnt_o), 0);
    chk(pix_cnt_o == 8'd20, "R8 pixels after recovery", int'(pix_cnt_o), 20);
  endtask

  task automatic t_clr_collide;
    frame(1, 6, -1, '0);
    cyc(1, 0, 0, '0);
    cyc(1, 0, 1, 24'h000100);
    chk(err_cnt_o == '0, "R9 clear beats error", int'(err_cnt_o), 0);
    chk(pix_cnt_o == '0, "R9 clear beats pixel", int'(pix_cnt_o), 0);
    cyc(1, 0, 0, 24'h000100);
    chk(err_cnt_o == 8'd1, "R9 count after clear", int'(err_cnt_o), 1);
    chk(pix_cnt_o == 8'd1, "R9 pixel after clear", int'(pix_cnt_o), 1);
    cyc(0, 0, 0, '0);
  endtask

  task automatic t_sat;
    cyc(0, 0, 1, '0);
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, 24'h000001);
    chk(pix_cnt_o == 8'hFF, "R10 pixel saturate", int'(pix_cnt_o), MAXC);
    chk(err_cnt_o == 8'hFF, "R10 error saturate", int'(err_cnt_o), MAXC);
    cyc(1, 0, 0, 24'h400000);
    chk(err_cnt_o == 8'hFF, "R10 error held", int'(err_cnt_o), MAXC);
    chk_model("R10");
    cyc(0, 0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_prelock();
    t_clean();
    t_single();
    t_multi();
    t_blank();
    t_resync();
    t_clr_collide();
    t_sat();
    chk_model("R6 final");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule